// File: doc/BRIEF.md
# Two-Level CCD Clock Waveform Sequencer

This block generates the digital clock pattern that reads out a CCD, together with the internal strobes that time the rest of the readout chain. One of those strobes is the ADC convert trigger, so the waveform itself sets the moment each pixel is sampled. The pattern is built in two levels. The lower level is a store of clocking units. A unit is a short run of output words, and each word carries a hold time in base clock cycles. One unit performs one action, for example a parallel row shift or a serial pixel shift. The upper level is a sequence program that calls units, repeats them, and can wrap a group of calls in one level of loop. A typical use is one parallel shift followed by a row of serial shifts, repeated for every row.

The host loads both stores and an idle output word through one write port while the sequencer is stopped. A start pulse launches a run from sequence entry 0. Busy stays high while the run lasts. A done pulse marks normal completion. An abort input ends a run at once. The 64-bit output word is registered. Its low half drives the CCD clock lines and its high half drives the internal strobes.

Top module: `ccd_wave_sequencer`

## Requirements
- R1: After a synchronous active-low reset, all 64 output bits are 0, busy and done are 0, and the stored idle word is 0.
- R2: A host write with wr_en high while busy is low updates one store, selected by wr_sel. Code 0 writes the unit entry at wr_addr: output word in wr_data[63:0], hold count in wr_data[79:64], last-entry flag in wr_data[80]. Code 1 writes the sequence entry at wr_addr[2:0]: repeat count in [15:0], unit start address in [19:16], kind in [21:20] (0 call, 1 loop begin, 2 loop end), end flag in [22]. Code 2 writes the idle word from wr_data[63:0].
- R3: A start sampled while idle raises busy in the next cycle. Each fetched word appears on the outputs one cycle after its fetch, so the first word is visible two cycles after start.
- R4: Each word of a unit stays on the outputs for exactly its hold count of cycles, and a hold count of 0 behaves as 1. The words of a unit play back to back until the entry flagged last.
- R5: A call with repeat count N plays its unit N times with no gap. After a non-final call, the last word is held for one extra cycle. Every loop-begin, loop-end and skipped entry takes one cycle and keeps the outputs unchanged.
- R6: A call whose repeat count is 0 is skipped and plays nothing.
- R7: A loop-end entry with count N sends the program back to the entry after the most recent loop-begin until the body has run N times in total. A count of 0 or 1 runs the body once.
- R8: When the run reaches an entry with the end flag set and that entry completes, the outputs return to the idle word, busy falls, and done is high for exactly that one cycle.
- R9: Abort during a run returns the outputs to the idle word in the next cycle, with busy low and no done pulse.
- R10: While busy is high, host writes to any store and further start pulses have no effect.
- R11: While idle, the outputs follow the stored idle word with one register delay.
- R12: ccd_clk carries output bits [31:0] and ctrl_strobe carries bits [63:32]. adc_conv equals bit 32, the lowest strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run from sequence entry 0 |
| abort | input | 1 | Stop a run and return to the idle word |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Target store: 0 unit, 1 sequence, 2 idle word |
| wr_addr | input | 4 | Entry address for the write |
| wr_data | input | 81 | Write data, field layout per R2 |
| ccd_clk | output | 32 | CCD clock lines |
| ctrl_strobe | output | 32 | Internal control strobes |
| adc_conv | output | 1 | ADC convert trigger |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on normal completion |

## Verification
Each run's expected cycle trace is computed from the programmed stores and compared cycle by cycle. A sweep over hold counts 0 to 3 and repeat counts 1 to 3 separates an off-by-one in dwell timing, in unit repetition and in the zero-hold rule. Separate programs exercise skipped calls, a loop body that mixes a single call with a repeated call, and a loop-end count of 0. These tell apart a loop that returns to the wrong entry, runs one time too many, or treats an empty count badly. Writes and a start pulse issued mid-run, followed by an abort and a rerun, show whether the stores stay locked and whether abort leaves the outputs in the right state.

// File: rtl/ccdseq_pkg.sv
// Shared encodings for the two-level CCD waveform sequencer.
// Assumes: sequence entry kind is a 2-bit field, host select is 2 bits.
package ccdseq_pkg;
    typedef enum logic [1:0] {
        EK_CALL       = 2'd0,
        EK_LOOP_BEGIN = 2'd1,
        EK_LOOP_END   = 2'd2,
        EK_RSVD       = 2'd3
    } entry_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_STEP  = 2'd1,
        PS_DWELL = 2'd2
    } phase_e;

    localparam logic [1:0] WSEL_UNIT = 2'd0;
    localparam logic [1:0] WSEL_SEQ  = 2'd1;
    localparam logic [1:0] WSEL_IDLE = 2'd2;
endpackage

// File: rtl/ccdseq_unit_store.sv
// Clocking-unit store: one entry is {last flag, hold count, output word}.
// Assumes: writes are already qualified by the caller; read is combinational.
module ccdseq_unit_store #(
    parameter int OUT_W   = 64,
    parameter int DWELL_W = 16,
    parameter int AW      = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [OUT_W+DWELL_W:0]   wdata,
    input  logic [AW-1:0]            raddr,
    output logic [OUT_W-1:0]         rvec,
    output logic [DWELL_W-1:0]       rdwell,
    output logic                     rlast
);
    localparam int DEPTH = 1 << AW;
    localparam int W     = OUT_W + DWELL_W + 1;

    logic [W-1:0] mem [DEPTH];

    // Host write of one unit entry.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Field split of the addressed entry.
    always_comb begin
        rvec   = mem[raddr][OUT_W-1:0];
        rdwell = mem[raddr][OUT_W+DWELL_W-1:OUT_W];
        rlast  = mem[raddr][W-1];
    end
endmodule

// File: rtl/ccdseq_prog_store.sv
// Sequence program store: {end flag, kind, unit start address, repeat count}.
// Assumes: writes are already qualified by the caller; read is combinational.
module ccdseq_prog_store
    import ccdseq_pkg::*;
#(
    parameter int REP_W   = 16,
    parameter int UNIT_AW = 4,
    parameter int AW      = 3
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [REP_W+UNIT_AW+2:0]    wdata,
    input  logic [AW-1:0]               raddr,
    output logic [REP_W-1:0]            rcount,
    output logic [UNIT_AW-1:0]          runit,
    output entry_kind_e                 rkind,
    output logic                        rend
);
    localparam int DEPTH = 1 << AW;
    localparam int W     = REP_W + UNIT_AW + 3;
    localparam int KPOS  = REP_W + UNIT_AW;

    logic [W-1:0] mem [DEPTH];

    // Host write of one sequence entry.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Field split of the entry under the program counter.
    always_comb begin
        rcount = mem[raddr][REP_W-1:0];
        runit  = mem[raddr][KPOS-1:REP_W];
        rkind  = entry_kind_e'(mem[raddr][KPOS+1:KPOS]);
        rend   = mem[raddr][W-1];
    end
endmodule

// File: rtl/ccdseq_engine.sv
// Sequencer engine: walks the program, plays units, keeps one loop level.
// Assumes: stores read combinationally at u_raddr / s_pc; output is registered.
module ccdseq_engine
    import ccdseq_pkg::*;
#(
    parameter int OUT_W   = 64,
    parameter int DWELL_W = 16,
    parameter int REP_W   = 16,
    parameter int UNIT_AW = 4,
    parameter int SEQ_AW  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic [OUT_W-1:0]     idle_vec,
    input  logic [OUT_W-1:0]     u_vec,
    input  logic [DWELL_W-1:0]   u_dwell,
    input  logic                 u_last,
    output logic [UNIT_AW-1:0]   u_raddr,
    input  logic [REP_W-1:0]     s_count,
    input  logic [UNIT_AW-1:0]   s_unit,
    input  entry_kind_e          s_kind,
    input  logic                 s_end,
    output logic [SEQ_AW-1:0]    s_pc,
    output logic [OUT_W-1:0]     out_vec,
    output logic                 busy,
    output logic                 done
);
    phase_e               phase;
    logic [SEQ_AW-1:0]    pc, loop_pc;
    logic [REP_W-1:0]     loop_iter, reps_left;
    logic [UNIT_AW-1:0]   uptr, ustart;
    logic [DWELL_W-1:0]   dwell_left, dwell_eff;
    logic                 cur_last, loop_again;

    // Effective hold count and loop decision for the current entry.
    always_comb begin
        dwell_eff  = (u_dwell == '0) ? DWELL_W'(1) : u_dwell;
        loop_again = ({1'b0, loop_iter} + (REP_W+1)'(1)) < {1'b0, s_count};
    end

    // Next unit word address: call target, next word, or unit restart.
    always_comb begin
        if (phase == PS_STEP)  u_raddr = s_unit;
        else if (cur_last)     u_raddr = ustart;
        else                   u_raddr = uptr + UNIT_AW'(1);
    end

    assign s_pc = pc;
    assign busy = (phase != PS_IDLE);

    // Run control, dwell timing and registered output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PS_IDLE;
            pc         <= '0;
            loop_pc    <= '0;
            loop_iter  <= '0;
            reps_left  <= '0;
            uptr       <= '0;
            ustart     <= '0;
            dwell_left <= '0;
            cur_last   <= 1'b0;
            out_vec    <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort && phase != PS_IDLE) begin
                phase   <= PS_IDLE;
                out_vec <= idle_vec;
            end else begin
                unique case (phase)
                    PS_IDLE: begin
                        out_vec <= idle_vec;
                        if (start) begin
                            phase     <= PS_STEP;
                            pc        <= '0;
                            loop_pc   <= '0;
                            loop_iter <= '0;
                        end
                    end
                    PS_STEP: begin
                        if (s_kind == EK_CALL && s_count != '0) begin
                            out_vec    <= u_vec;
                            dwell_left <= dwell_eff;
                            cur_last   <= u_last;
                            uptr       <= s_unit;
                            ustart     <= s_unit;
                            reps_left  <= s_count;
                            phase      <= PS_DWELL;
                        end else if (s_kind == EK_LOOP_END && loop_again) begin
                            loop_iter <= loop_iter + REP_W'(1);
                            pc        <= loop_pc;
                        end else begin
                            if (s_kind == EK_LOOP_BEGIN) begin
                                loop_pc   <= pc + SEQ_AW'(1);
                                loop_iter <= '0;
                            end
                            if (s_end) begin
                                phase   <= PS_IDLE;
                                out_vec <= idle_vec;
                                done    <= 1'b1;
                            end else begin
                                pc <= pc + SEQ_AW'(1);
                            end
                        end
                    end
                    PS_DWELL: begin
                        if (dwell_left > DWELL_W'(1)) begin
                            dwell_left <= dwell_left - DWELL_W'(1);
                        end else if (!cur_last) begin
                            out_vec    <= u_vec;
                            dwell_left <= dwell_eff;
                            cur_last   <= u_last;
                            uptr       <= uptr + UNIT_AW'(1);
                        end else if (reps_left > REP_W'(1)) begin
                            out_vec    <= u_vec;
                            dwell_left <= dwell_eff;
                            cur_last   <= u_last;
                            uptr       <= ustart;
                            reps_left  <= reps_left - REP_W'(1);
                        end else if (s_end) begin
                            phase   <= PS_IDLE;
                            out_vec <= idle_vec;
                            done    <= 1'b1;
                        end else begin
                            pc    <= pc + SEQ_AW'(1);
                            phase <= PS_STEP;
                        end
                    end
                    default: phase <= PS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ccd_wave_sequencer.sv
// Top: host write port, idle word register, both stores and the engine.
// Assumes: SEQ_AW <= UNIT_AW and sequence entry fits in the write data width.
module ccd_wave_sequencer
    import ccdseq_pkg::*;
#(
    parameter int CLK_W   = 32,
    parameter int CTRL_W  = 32,
    parameter int DWELL_W = 16,
    parameter int REP_W   = 16,
    parameter int UNIT_AW = 4,
    parameter int SEQ_AW  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              abort,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_sel,
    input  logic [UNIT_AW-1:0]                wr_addr,
    input  logic [CLK_W+CTRL_W+DWELL_W:0]     wr_data,
    output logic [CLK_W-1:0]                  ccd_clk,
    output logic [CTRL_W-1:0]                 ctrl_strobe,
    output logic                              adc_conv,
    output logic                              busy,
    output logic                              done
);
    localparam int OUT_W = CLK_W + CTRL_W;
    localparam int SEQ_W = REP_W + UNIT_AW + 3;

    logic [OUT_W-1:0]    idle_q, out_vec, u_vec;
    logic [DWELL_W-1:0]  u_dwell;
    logic                u_last, s_end, wr_ok;
    logic [UNIT_AW-1:0]  u_raddr, s_unit;
    logic [REP_W-1:0]    s_count;
    logic [SEQ_AW-1:0]   s_pc;
    entry_kind_e         s_kind;

    assign wr_ok = wr_en && !busy;

    // Idle word register, loadable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                            idle_q <= '0;
        else if (wr_ok && wr_sel == WSEL_IDLE) idle_q <= wr_data[OUT_W-1:0];
    end

    ccdseq_unit_store #(.OUT_W(OUT_W), .DWELL_W(DWELL_W), .AW(UNIT_AW)) u_units (
        .clk(clk), .we(wr_ok && wr_sel == WSEL_UNIT), .waddr(wr_addr),
        .wdata(wr_data), .raddr(u_raddr),
        .rvec(u_vec), .rdwell(u_dwell), .rlast(u_last)
    );

    ccdseq_prog_store #(.REP_W(REP_W), .UNIT_AW(UNIT_AW), .AW(SEQ_AW)) u_prog (
        .clk(clk), .we(wr_ok && wr_sel == WSEL_SEQ), .waddr(wr_addr[SEQ_AW-1:0]),
        .wdata(wr_data[SEQ_W-1:0]), .raddr(s_pc),
        .rcount(s_count), .runit(s_unit), .rkind(s_kind), .rend(s_end)
    );

    ccdseq_engine #(
        .OUT_W(OUT_W), .DWELL_W(DWELL_W), .REP_W(REP_W),
        .UNIT_AW(UNIT_AW), .SEQ_AW(SEQ_AW)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .idle_vec(idle_q), .u_vec(u_vec), .u_dwell(u_dwell), .u_last(u_last),
        .u_raddr(u_raddr), .s_count(s_count), .s_unit(s_unit), .s_kind(s_kind),
        .s_end(s_end), .s_pc(s_pc), .out_vec(out_vec), .busy(busy), .done(done)
    );

    // Output split: clock lines low, strobes high, convert trigger is strobe 0.
    assign ccd_clk     = out_vec[CLK_W-1:0];
    assign ctrl_strobe = out_vec[OUT_W-1:CLK_W];
    assign adc_conv    = out_vec[CLK_W];
endmodule

// File: rtl/ccd_wave_sequencer_chk.sv
// Checker for run control, completion, abort and idle behaviour.
// Assumes: bound to ccd_wave_sequencer; sees the idle word register.
module ccd_wave_sequencer_chk #(
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] out_vec,
    input logic [OUT_W-1:0] idle_q
);
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !abort) |=> busy);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && out_vec == idle_q));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !done));

    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (idle_q == $past(idle_q)));

    a_r11_idle_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (out_vec == $past(idle_q)));
endmodule

bind ccd_wave_sequencer ccd_wave_sequencer_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy),
    .done(done), .out_vec({ctrl_strobe, ccd_clk}), .idle_q(idle_q)
);

// File: tb/ccd_wave_sequencer_test.sv
`timescale 1ns/1ps
module ccd_wave_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [3:0]  wr_addr = '0;
    logic [80:0] wr_data = '0;
    logic [31:0] ccd_clk, ctrl_strobe;
    logic        adc_conv, busy, done;

    int n_chk = 0;
    int n_err = 0;

    // Bench-side copy of what was programmed.
    logic [63:0] m_vec [16];
    int          m_dw  [16];
    bit          m_last[16];
    int          s_cnt [8];
    int          s_unit[8];
    int          s_kind[8];
    bit          s_end [8];
    logic [63:0] idle_m = '0;

    logic [63:0] exp_tr [0:4095];
    int          exp_n;

    always #10 clk = ~clk;

    ccd_wave_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .ccd_clk(ccd_clk), .ctrl_strobe(ctrl_strobe), .adc_conv(adc_conv),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic hw_write(input logic [1:0] sel, input int a, input logic [80:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = a[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_unit(input int a, input logic [63:0] v, input int dw, input bit last);
        logic [80:0] d;
        d = {last, dw[15:0], v};
        hw_write(2'd0, a, d);
        m_vec[a] = v; m_dw[a] = dw; m_last[a] = last;
    endtask

    task automatic wr_seq(input int a, input int cnt, input int ua, input int kind, input bit e);
        logic [80:0] d;
        d = '0;
        d[15:0] = cnt[15:0]; d[19:16] = ua[3:0]; d[21:20] = kind[1:0]; d[22] = e;
        hw_write(2'd1, a, d);
        s_cnt[a] = cnt; s_unit[a] = ua; s_kind[a] = kind; s_end[a] = e;
    endtask

    task automatic wr_idle(input logic [63:0] v);
        hw_write(2'd2, 0, {17'd0, v});
        idle_m = v;
    endtask

    // Expected per-cycle output trace, from the timing rules R3-R8.
    task automatic build_exp();
        int n, pc, lpc, liter, guard;
        bit fin;
        logic [63:0] cur;
        n = 0; pc = 0; lpc = 0; liter = 0; guard = 0; fin = 0; cur = idle_m;
        exp_tr[n] = cur; n++;
        while (!fin && guard < 300 && n < 4000) begin
            guard++;
            if (s_kind[pc] == 0 && s_cnt[pc] != 0) begin
                for (int r = 0; r < s_cnt[pc]; r++) begin
                    int a; bit lf;
                    a = s_unit[pc]; lf = 0;
                    while (!lf) begin
                        int d;
                        d = (m_dw[a] == 0) ? 1 : m_dw[a];
                        for (int k = 0; k < d; k++) begin exp_tr[n] = m_vec[a]; n++; end
                        cur = m_vec[a]; lf = m_last[a]; a = (a + 1) % 16;
                    end
                end
                if (s_end[pc]) fin = 1;
                else begin exp_tr[n] = cur; n++; pc = (pc + 1) % 8; end
            end else if (s_kind[pc] == 2 && liter + 1 < s_cnt[pc]) begin
                liter++; pc = lpc; exp_tr[n] = cur; n++;
            end else begin
                if (s_kind[pc] == 1) begin lpc = (pc + 1) % 8; liter = 0; end
                if (s_end[pc]) fin = 1;
                else begin pc = (pc + 1) % 8; exp_tr[n] = cur; n++; end
            end
        end
        exp_n = n;
    endtask

    // Launch a run and compare every busy cycle against the expected trace.
    task automatic run_check(input string req);
        int idx, mism;
        logic [63:0] bad_a, bad_e;
        build_exp();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idx = 0; mism = 0; bad_a = '0; bad_e = '0;
        while (busy && idx < 4090) begin
            if ({ctrl_strobe, ccd_clk} !== exp_tr[idx] || adc_conv !== exp_tr[idx][32]) begin
                if (mism == 0) begin bad_a = {ctrl_strobe, ccd_clk}; bad_e = exp_tr[idx]; end
                mism++;
            end
            idx++;
            @(negedge clk);
        end
        chk(idx == exp_n, req, "busy length", 64'(idx), 64'(exp_n));
        chk(mism == 0, {req, " R12"}, "trace word", bad_a, bad_e);
        chk(done === 1'b1 && {ctrl_strobe, ccd_clk} === idle_m, "R8", "done/idle at end",
            {ctrl_strobe, ccd_clk}, idle_m);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done pulse width", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_vec[i] = '0; m_dw[i] = 0; m_last[i] = 1; end
        for (int i = 0; i < 8; i++) begin s_cnt[i] = 0; s_unit[i] = 0; s_kind[i] = 0; s_end[i] = 1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({ctrl_strobe, ccd_clk} === 64'd0, "R1", "outputs", {ctrl_strobe, ccd_clk}, 64'd0);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", {62'd0, busy, done}, 64'd0);

        // R11: idle word reaches outputs one register after the write
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = {17'd0, 64'h0F0F_0000_0000_00F0};
        @(negedge clk); wr_en = 1'b0; idle_m = 64'h0F0F_0000_0000_00F0;
        chk({ctrl_strobe, ccd_clk} === 64'd0, "R11", "before delay", {ctrl_strobe, ccd_clk}, 64'd0);
        @(negedge clk);
        chk({ctrl_strobe, ccd_clk} === idle_m, "R11", "after delay", {ctrl_strobe, ccd_clk}, idle_m);

        // R2: program units A(0..2), B(3..4), C(5)
        wr_unit(0, 64'h0000_0000_0000_0003, 1, 0);
        wr_unit(1, 64'h0000_0001_0000_0005, 2, 0);
        wr_unit(2, 64'h0000_0000_0000_0009, 3, 1);
        wr_unit(3, 64'hAAAA_0000_0000_0100, 0, 0);
        wr_unit(4, 64'h0000_0002_0000_0200, 1, 1);
        wr_unit(5, 64'h0000_0000_8000_0000, 2, 1);

        // R3 R4 R5: unit A called twice, then end
        wr_seq(0, 2, 0, 0, 1);
        run_check("R3 R4 R5");

        // R6 R4: skipped call, zero hold in unit B
        wr_seq(0, 0, 3, 0, 0);
        wr_seq(1, 1, 5, 0, 0);
        wr_seq(2, 1, 3, 0, 1);
        run_check("R6 R4");

        // R7: row loop with one parallel unit and three serial units, three rows
        wr_seq(0, 1, 5, 0, 0);
        wr_seq(1, 0, 0, 1, 0);
        wr_seq(2, 1, 0, 0, 0);
        wr_seq(3, 3, 3, 0, 0);
        wr_seq(4, 3, 0, 2, 1);
        run_check("R7 R5");

        // R7: loop-end count 0 runs the body once
        wr_seq(0, 0, 0, 1, 0);
        wr_seq(1, 2, 5, 0, 0);
        wr_seq(2, 0, 0, 2, 1);
        run_check("R7 zero count");

        // R4 R5 sweep: hold 0..3 on first word, repeats 1..3
        for (int d0 = 0; d0 < 4; d0++) begin
            for (int r = 1; r < 4; r++) begin
                wr_unit(6, 64'h0000_0001_0000_0041 + 64'(d0), d0, 0);
                wr_unit(7, 64'h5500_0000_0000_0082, 1, 1);
                wr_seq(0, r, 6, 0, 1);
                run_check("R4 R5 sweep");
            end
        end

        // R9 R10: writes and start during a long run, then abort
        wr_seq(0, 200, 5, 0, 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        hw_write(2'd2, 0, {17'd0, 64'hDEAD_BEEF_0000_0001});
        hw_write(2'd0, 5, {1'b1, 16'd7, 64'h1111_2222_3333_4444});
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R10", "still busy", 64'(busy), 64'd1);
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R9", "busy/done after abort",
            {62'd0, busy, done}, 64'd0);
        chk({ctrl_strobe, ccd_clk} === idle_m, "R9 R10", "idle word after abort",
            {ctrl_strobe, ccd_clk}, idle_m);
        // R10: unit 5 write during run must not have landed
        wr_seq(0, 2, 5, 0, 1);
        run_check("R10");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule